// File: doc/BRIEF.md
# LSB-First Successive Approximation Sequencer

This block is the digital sequencer of a 10-bit charge-redistribution converter. A plain SAR search starts at mid-scale and always resolves every bit from the top down. This sequencer works differently. Each conversion starts from the previous result as its guess. It first learns on which side of the guess the input lies. It then walks outward from the least-significant bit in steps that double each time, until the comparator reports that the DAC has crossed the input. Finally it binary-searches back down inside the bracket it has found. A slowly moving input therefore settles in a few bitcycles, and a full-scale jump costs at most 2N+1 bitcycles.

The block drives the DAC code word and one extra direction bit. The direction bit picks the lower edge of the code (level = code) or its upper edge (level = code + 1). It also drives the sample, DAC-enable and purge controls, and it receives a single comparator bit. At the end of each conversion it reports the result and the number of bitcycles the conversion used.

The states are IDLE, SAMPLE, INIT_LO, INIT_HI, GROW, REFINE and PURGE. The transitions are:
- IDLE→SAMPLE on start.
- SAMPLE→INIT_LO unconditionally.
- INIT_LO→GROW when the comparator is 1, otherwise INIT_LO→INIT_HI.
- INIT_HI→PURGE when the comparator is 1 (the guess was exact), otherwise INIT_HI→GROW.
- GROW→GROW while there is no overshoot.
- On overshoot, GROW→PURGE when the overshoot is at bit 0, otherwise GROW→REFINE.
- REFINE→REFINE while the bit index is above 0, and REFINE→PURGE at index 0.
- PURGE→IDLE unconditionally.

Top module: `lsbf_sar_seq`

## Requirements
- R1: After reset, result reads 511 (mid-scale), bitcycles reads 0, and sample, dac_en, purge and done are all 0.
- R2: A start pulse in IDLE gives exactly one cycle with sample=1 and dac_en=1. In the first bitcycle that follows, dac_code equals the previous result and dac_dir is 0.
- R3: The DAC level is dac_code + dac_dir, and cmp=1 means that level is above the input. With a comparator that returns 1 exactly when the level exceeds input code x (0..1023), the final result equals x.
- R4: The first bitcycle compares the lower edge. If cmp=0 there, dac_dir becomes 1 and the second bitcycle compares the upper edge. If that second compare returns 1, the guess was exact and the conversion ends after 2 bitcycles.
- R5: In GROW, bit k of the code is written with the dac_dir value for k = 0, 1, 2, …, one bit per bitcycle, until cmp equals dac_dir (overshoot). Overshoot is always reached by bit N-1.
- R6: In REFINE, starting one bit below the overshoot bit and moving down to bit 0, each bit is first written with the inverse of dac_dir. The bit keeps that value only if cmp equals dac_dir in its bitcycle; otherwise it is put back.
- R7: Every conversion takes between 2 and 2N+1 (21) bitcycles. The count is reported on bitcycles when done is high.
- R8: The conversion ends with exactly one PURGE cycle in which done=1, purge=1 and dac_en=0, with the new result already valid. That result becomes the next conversion's guess.
- R9: A start pulse that arrives while a conversion is running is ignored. No new sample cycle follows the PURGE cycle.
- R10: dac_dir changes only inside INIT_LO/INIT_HI. It is constant throughout GROW and REFINE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start-of-conversion strobe, honoured only in IDLE |
| cmp | input | 1 | Comparator result, 1 when DAC level exceeds input |
| dac_code | output | 10 | DAC code word |
| dac_dir | output | 1 | Edge select: 0 lower edge, 1 upper edge |
| sample | output | 1 | Input sampling control |
| dac_en | output | 1 | DAC enable during sampling and bitcycles |
| purge | output | 1 | DAC purge at end of conversion |
| done | output | 1 | One-cycle conversion-complete strobe |
| result | output | 10 | Final code, also the next guess |
| bitcycles | output | 5 | Bitcycles used by the last conversion |

## Verification
Each conversion uses a fixed series of bitcycles, and each one shows a (code, direction) pair on the DAC pins. A wrong state, bit index or direction therefore shows up on the pins in the first bitcycle where the pair departs from the expected walk. A wrong restore decision in REFINE may show only at done, as a wrong result. A wrong stored guess shows up at the first bitcycle of the next conversion. Because the expected walk depends strongly on the previous code, back-to-back cases are chosen to stress it: the mid-scale guess, a one-code step down, a one-code step up, full-scale swings and slow ramps.

// File: rtl/lsbf_sar_pkg.sv
package lsbf_sar_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SAMPLE,
        S_INIT_LO,
        S_INIT_HI,
        S_GROW,
        S_REFINE,
        S_PURGE
    } seq_state_t;

endpackage

// File: rtl/lsbf_sar_fsm.sv
module lsbf_sar_fsm
    import lsbf_sar_pkg::*;
#(
    parameter int N     = 10,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp,
    input  logic             dir_i,
    output logic             load,
    output logic             set_dir,
    output logic             commit,
    output logic             cnt_inc,
    output logic             walk,
    output logic             wr0_en,
    output logic [IDX_W-1:0] wr0_idx,
    output logic             wr0_val,
    output logic             wr1_en,
    output logic [IDX_W-1:0] wr1_idx,
    output logic             wr1_val,
    output logic             sample,
    output logic             dac_en,
    output logic             purge,
    output logic             done
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(N - 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             overshoot;

    // Overshoot (GROW) and keep (REFINE) share one test: comparator equals direction.
    assign overshoot = (cmp == dir_i);

    // State and bit index register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Next state, index and code-update commands.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        load    = 1'b0;
        set_dir = 1'b0;
        commit  = 1'b0;
        cnt_inc = 1'b0;
        wr0_en  = 1'b0;
        wr0_idx = '0;
        wr0_val = 1'b0;
        wr1_en  = 1'b0;
        wr1_idx = '0;
        wr1_val = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    state_d = S_SAMPLE;
                end
            end
            S_SAMPLE: begin
                state_d = S_INIT_LO;
            end
            S_INIT_LO: begin
                cnt_inc = 1'b1;
                if (cmp) begin
                    // guess above input: step downward starting at bit 0
                    wr0_en  = 1'b1;
                    wr0_idx = '0;
                    wr0_val = dir_i;
                    idx_d   = '0;
                    state_d = S_GROW;
                end else begin
                    set_dir = 1'b1;
                    state_d = S_INIT_HI;
                end
            end
            S_INIT_HI: begin
                cnt_inc = 1'b1;
                if (cmp) begin
                    commit  = 1'b1;
                    state_d = S_PURGE;
                end else begin
                    wr0_en  = 1'b1;
                    wr0_idx = '0;
                    wr0_val = dir_i;
                    idx_d   = '0;
                    state_d = S_GROW;
                end
            end
            S_GROW: begin
                cnt_inc = 1'b1;
                if (overshoot) begin
                    if (idx_q == '0) begin
                        commit  = 1'b1;
                        state_d = S_PURGE;
                    end else begin
                        wr0_en  = 1'b1;
                        wr0_idx = idx_q - 1'b1;
                        wr0_val = ~dir_i;
                        idx_d   = idx_q - 1'b1;
                        state_d = S_REFINE;
                    end
                end else if (idx_q == TOP_IDX) begin
                    commit  = 1'b1;
                    state_d = S_PURGE;
                end else begin
                    wr0_en  = 1'b1;
                    wr0_idx = idx_q + 1'b1;
                    wr0_val = dir_i;
                    idx_d   = idx_q + 1'b1;
                end
            end
            S_REFINE: begin
                cnt_inc = 1'b1;
                if (!overshoot) begin
                    // trial rejected: put the bit back
                    wr0_en  = 1'b1;
                    wr0_idx = idx_q;
                    wr0_val = dir_i;
                end
                if (idx_q == '0) begin
                    commit  = 1'b1;
                    state_d = S_PURGE;
                end else begin
                    wr1_en  = 1'b1;
                    wr1_idx = idx_q - 1'b1;
                    wr1_val = ~dir_i;
                    idx_d   = idx_q - 1'b1;
                end
            end
            S_PURGE: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Port-level controls decoded from the state.
    always_comb begin
        sample = 1'b0;
        dac_en = 1'b0;
        purge  = 1'b0;
        done   = 1'b0;
        walk   = 1'b0;
        unique case (state_q)
            S_IDLE:    ;
            S_SAMPLE:  begin sample = 1'b1; dac_en = 1'b1; end
            S_INIT_LO: dac_en = 1'b1;
            S_INIT_HI: dac_en = 1'b1;
            S_GROW:    begin dac_en = 1'b1; walk = 1'b1; end
            S_REFINE:  begin dac_en = 1'b1; walk = 1'b1; end
            S_PURGE:   begin purge = 1'b1; done = 1'b1; end
            default:   ;
        endcase
    end

    // Walking past the top bit without an overshoot cannot happen with a consistent comparator.
    assert_grow_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GROW && idx_q == TOP_IDX) |-> overshoot);

    // done lasts a single cycle.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Sampling is followed by a bitcycle, never a second sample cycle.
    assert_sample_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> (dac_en && !sample));

endmodule

// File: rtl/lsbf_sar_code.sv
module lsbf_sar_code #(
    parameter int N     = 10,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             set_dir,
    input  logic             commit,
    input  logic             walk,
    input  logic             wr0_en,
    input  logic [IDX_W-1:0] wr0_idx,
    input  logic             wr0_val,
    input  logic             wr1_en,
    input  logic [IDX_W-1:0] wr1_idx,
    input  logic             wr1_val,
    output logic [N-1:0]     code_q,
    output logic             dir_q,
    output logic [N-1:0]     result_q
);

    localparam logic [N-1:0] MID = N'((1 << (N - 1)) - 1);

    logic [N-1:0] code_d;

    // Per-bit update: second port has priority, then first, else hold.
    for (genvar b = 0; b < N; b++) begin : g_bit
        always_comb begin
            if (wr1_en && wr1_idx == IDX_W'(b))
                code_d[b] = wr1_val;
            else if (wr0_en && wr0_idx == IDX_W'(b))
                code_d[b] = wr0_val;
            else
                code_d[b] = code_q[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q   <= '0;
            dir_q    <= 1'b0;
            result_q <= MID;
        end else begin
            if (load) begin
                code_q <= result_q;
                dir_q  <= 1'b0;
            end else begin
                code_q <= code_d;
                if (set_dir)
                    dir_q <= 1'b1;
            end
            if (commit)
                result_q <= code_d;
        end
    end

    // The first bitcycle shows the stored previous result on the lower edge.
    assert_guess_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (code_q == $past(result_q) && !dir_q));

    // Direction frozen while walking outward and back.
    assert_dir_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (walk && $past(walk)) |-> $stable(dir_q));

endmodule

// File: rtl/lsbf_sar_count.sv
module lsbf_sar_count #(
    parameter int N     = 10,
    parameter int CNT_W = $clog2(2 * N + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             commit,
    output logic [CNT_W-1:0] bitcycles_q
);

    localparam logic [CNT_W-1:0] MAX_BC = CNT_W'(2 * N + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            bitcycles_q <= '0;
        end else begin
            if (clr)
                cnt_q <= '0;
            else if (inc)
                cnt_q <= cnt_q + 1'b1;
            if (commit)
                bitcycles_q <= cnt_q + 1'b1;
        end
    end

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (bitcycles_q >= CNT_W'(2) && bitcycles_q <= MAX_BC));

endmodule

// File: rtl/lsbf_sar_seq.sv
module lsbf_sar_seq #(
    parameter int N     = 10,
    parameter int IDX_W = $clog2(N),
    parameter int CNT_W = $clog2(2 * N + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp,
    output logic [N-1:0]     dac_code,
    output logic             dac_dir,
    output logic             sample,
    output logic             dac_en,
    output logic             purge,
    output logic             done,
    output logic [N-1:0]     result,
    output logic [CNT_W-1:0] bitcycles
);

    logic             load, set_dir, commit, cnt_inc, walk;
    logic             wr0_en, wr0_val, wr1_en, wr1_val;
    logic [IDX_W-1:0] wr0_idx, wr1_idx;

    lsbf_sar_fsm #(.N(N), .IDX_W(IDX_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cmp     (cmp),
        .dir_i   (dac_dir),
        .load    (load),
        .set_dir (set_dir),
        .commit  (commit),
        .cnt_inc (cnt_inc),
        .walk    (walk),
        .wr0_en  (wr0_en),
        .wr0_idx (wr0_idx),
        .wr0_val (wr0_val),
        .wr1_en  (wr1_en),
        .wr1_idx (wr1_idx),
        .wr1_val (wr1_val),
        .sample  (sample),
        .dac_en  (dac_en),
        .purge   (purge),
        .done    (done)
    );

    lsbf_sar_code #(.N(N), .IDX_W(IDX_W)) u_code (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .set_dir  (set_dir),
        .commit   (commit),
        .walk     (walk),
        .wr0_en   (wr0_en),
        .wr0_idx  (wr0_idx),
        .wr0_val  (wr0_val),
        .wr1_en   (wr1_en),
        .wr1_idx  (wr1_idx),
        .wr1_val  (wr1_val),
        .code_q   (dac_code),
        .dir_q    (dac_dir),
        .result_q (result)
    );

    lsbf_sar_count #(.N(N), .CNT_W(CNT_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (load),
        .inc         (cnt_inc),
        .commit      (commit),
        .bitcycles_q (bitcycles)
    );

    // A purge cycle never drives the DAC.
    assert_purge_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        purge |-> (!dac_en && done));

endmodule

// File: tb/lsbf_sar_seq_bench.sv
module lsbf_sar_seq_bench;

    localparam int N = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cmp;
    logic [9:0]  dac_code;
    logic        dac_dir;
    logic        sample, dac_en, purge, done;
    logic [9:0]  result;
    logic [4:0]  bitcycles;
    int          vin = 0;

    int checks = 0;
    int errors = 0;
    int exp_q[$];

    always #4 clk = ~clk;

    // Behavioural DAC + comparator: level = code + dir, compared against input code.
    assign cmp = ((int'(dac_code) + int'(dac_dir)) > vin);

    lsbf_sar_seq u_lsbf_sar_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp(cmp),
        .dac_code(dac_code), .dac_dir(dac_dir), .sample(sample),
        .dac_en(dac_en), .purge(purge), .done(done),
        .result(result), .bitcycles(bitcycles)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected DAC walk as entries dir*1024+code, one per bitcycle.
    task automatic build(input int p, input int x);
        int d = p;
        int dir = 0;
        int k = 0;
        exp_q.delete();
        exp_q.push_back(d);
        if (d <= x) begin
            dir = 1;
            exp_q.push_back(1024 + d);
            if (d + 1 > x) return;
        end
        for (int s = 0; s < N; s++) begin
            int span = (2 << s) - 1;
            if (dir == 1) d = d | span; else d = d & ~span;
            exp_q.push_back(dir * 1024 + d);
            k = s;
            if (((d + dir) > x) == (dir == 1)) break;
        end
        for (int b = k - 1; b >= 0; b--) begin
            int old = d;
            if (dir == 1) d = d & ~(1 << b); else d = d | (1 << b);
            exp_q.push_back(dir * 1024 + d);
            if (((d + dir) > x) != (dir == 1)) d = old;
        end
    endtask

    task automatic convert(input int x, input int exp_bc, input bit poke);
        int prev = int'(result);
        int n_exp;
        int cyc = 0;
        bit trace_ok = 1'b1;
        build(prev, x);
        n_exp = exp_q.size();
        vin = x;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(sample === 1'b1 && dac_en === 1'b1, "R2 sample", int'(sample), 1);
        forever begin
            @(negedge clk);
            cyc++;
            if (done === 1'b1 || cyc > 60) break;
            start = (poke && cyc == 3);
            if (exp_q.size() == 0) begin
                trace_ok = 1'b0;
                $display("FAIL R5 R6 extra bitcycle actual=%0d expected=%0d", int'(dac_code), -1);
            end else begin
                int e = exp_q.pop_front();
                int a = int'(dac_dir) * 1024 + int'(dac_code);
                if (a != e) begin
                    trace_ok = 1'b0;
                    $display("FAIL R2 R4 R5 R6 walk actual=%0d expected=%0d", a, e);
                end
            end
        end
        start = 1'b0;
        check(trace_ok, "R5 R6 walk", 0, 0);
        check(done === 1'b1, "R8 done reached", int'(done), 1);
        check(int'(result) == x, "R3 result", int'(result), x);
        check(int'(bitcycles) == n_exp, "R7 bitcycles", int'(bitcycles), n_exp);
        check(bitcycles >= 2 && bitcycles <= 21, "R7 bound", int'(bitcycles), 21);
        if (exp_bc >= 0)
            check(int'(bitcycles) == exp_bc, "R4 R7 known count", int'(bitcycles), exp_bc);
        check(purge === 1'b1 && dac_en === 1'b0, "R8 purge", int'(purge), 1);
        @(negedge clk);
        check(done === 1'b0 && purge === 1'b0, "R8 single done", int'(done), 0);
        check(sample === 1'b0 && dac_en === 1'b0, "R9 no restart", int'(sample), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(int'(result) == 511, "R1 result", int'(result), 511);
        check(bitcycles == 0, "R1 bitcycles", int'(bitcycles), 0);
        check({sample, dac_en, purge, done} == 4'b0, "R1 controls", int'({sample, dac_en, purge, done}), 0);

        convert(511, 2, 1'b0);    // R4 exact guess
        convert(510, 2, 1'b0);    // one step down
        convert(512, 21, 1'b1);   // R7 worst case, R9 start poked mid-run
        convert(0, 20, 1'b0);     // full swing down
        convert(1023, 21, 1'b0);  // full swing up from zero
        convert(1023, 2, 1'b0);   // R8 result reused as guess
        // slowly varying ramp
        for (int i = 0; i < 12; i++) convert(600 + 3 * i - (i % 4), -1, 1'b0);
        // pseudo-random inputs
        for (int i = 0; i < 40; i++) begin
            lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
            convert(lfsr % 1024, -1, (i % 7) == 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule